// File: doc/BRIEF.md
# Multispeed Fiber Link Autotry Sequencer

This block brings up an optical link whose top rate cannot be negotiated with the far end. When it is started, it walks through the requested speeds one at a time, fastest first. Each attempt drives the module rate-select output, waits for the module's analog front end to settle, and, when a restart has been requested, briefly switches the transmit laser off and back on so that the partner restarts its own attempt. It then watches the link-up input across one or more fixed poll windows.

All waits are counted in pulses of a shared timebase `tick`. The default parameters assume one tick every 100 us. The speed masks use bit 1 for the 10G speed and bit 0 for the 1G speed. `rate_select` is 1 for the 10G setting and 0 for the 1G setting. When the run ends, the block raises `done` for one cycle. `fail` and `adv_speed` hold the outcome until the next run ends.

Top module: `msf_autotry`

## Requirements
- R1: On `start`, the effective speed set is `req_speed & sup_speed`, and a speed outside that set is never attempted: `rate_select` never moves to an unsupported speed.
- R2: The 10G attempt (bit 1) is made before the 1G attempt (bit 0). An attempt sets `rate_select` to its speed in the cycle after that attempt begins.
- R3: If `link_up` is already high at the attempted speed when an attempt begins (`link_at_hi`=1 for 10G, 0 for 1G), the run ends successfully in the next cycle and `rate_select` is left unchanged.
- R4: After `rate_select` is set, the block waits `SETTLE_TICKS` tick pulses before it flaps the laser or polls the link.
- R5: If a flap is pending when settling ends, `laser_off` is high for exactly `DARK_TICKS` tick pulses, then low for `LIGHT_TICKS` pulses, and polling starts only after that. With no flap pending, `laser_off` stays low.
- R6: A pulse on `restart_req` marks a flap as pending. The pending mark clears when the dark phase ends, so at most one flap happens per request. A request made in the same cycle as the clear wins.
- R7: The 10G attempt samples `link_up` at the end of each of up to `POLLS_HI` windows of `POLL_TICKS` pulses. It ends with success at the first sample that sees link.
- R8: The 1G attempt samples `link_up` once, at the end of a single `POLLS_LO` window of `POLL_TICKS` pulses.
- R9: If no attempt links and both speeds were attempted, `rate_select` returns to 10G. If only one speed was attempted, `rate_select` is left where that attempt put it.
- R10: At the end of every run, `done` is high for exactly one cycle, `fail` is 1 when no link was obtained and 0 otherwise, and `adv_speed` equals the effective speed set.
- R11: A `start` pulse while a run is in progress is ignored. Only one `done` results, and the speed set of the running attempt is kept.
- R12: An empty effective speed set ends the run with `fail`=1 and `adv_speed`=0 three cycles after `start`, without touching `rate_select`.
- R13: After reset, `rate_select`, `laser_off`, `adv_speed`, `done` and `fail` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an autotry run (pulse) |
| restart_req | input | 1 | Request a laser flap on the next attempt (pulse) |
| req_speed | input | 2 | Requested speeds, bit 1 = 10G, bit 0 = 1G |
| sup_speed | input | 2 | Supported speeds, same encoding |
| link_up | input | 1 | Link status from the receive path |
| link_at_hi | input | 1 | Current link runs at 10G (1) or 1G (0) |
| tick | input | 1 | Timebase pulse, one cycle wide |
| rate_select | output | 1 | Module rate select, 1 = 10G |
| laser_off | output | 1 | Transmit laser disable |
| adv_speed | output | 2 | Advertised speeds at the end of the run |
| done | output | 1 | One-cycle end-of-run pulse |
| fail | output | 1 | Last run obtained no link |

## Verification
The bench goes after four kinds of mistake.

- Fallback: it runs with both speeds requested and with only 1G supported, while the link never comes up. A design that falls back after a single attempt would wrongly move `rate_select` to 10G, and one that skips the fallback would leave it at 1G after a two-speed failure.
- Flap counting: it counts the cycles and pulses of the laser flap. A pending mark that never clears would flap again on the 1G attempt, and a tick counter that is off by one would show a dark pulse of the wrong length.
- Early and late links: it raises link before the start and in the middle of the third 10G window. A design that ignores the speed of an existing link, or that samples the link at the wrong point in a window, would report a different outcome or end on a different cycle than the reference model.
- Stray inputs: it injects a second start during a run and a request whose speeds are all unsupported. Both would show up as extra `done` pulses or as wrong values on `adv_speed`.

// File: rtl/msf_pkg.sv
package msf_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHK_HI,
        ST_CHK_LO,
        ST_SETTLE,
        ST_DARK,
        ST_LIGHT,
        ST_POLL,
        ST_FALLBACK
    } msf_state_e;

    typedef struct packed {
        logic hi;   // 10G
        logic lo;   // 1G
    } spd_mask_t;

    function automatic logic is_timed(msf_state_e s);
        return (s == ST_SETTLE) || (s == ST_DARK) || (s == ST_LIGHT) || (s == ST_POLL);
    endfunction

    function automatic int imax(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/msf_phase_timer.sv
module msf_phase_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          tick,
    input  logic [CW-1:0] limit,
    output logic          expire
);
    logic [CW-1:0] cnt;

    assign expire = !clr && tick && (cnt == limit - CW'(1));

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (tick)
            cnt <= expire ? '0 : cnt + CW'(1);
    end

    // Phase counter never runs past the window it is timing
    p_cnt_below_limit_r4: assert property (@(posedge clk) disable iff (rst)
        !clr |-> (cnt < limit));

endmodule

// File: rtl/msf_flap_flag.sv
module msf_flap_flag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic pending
);
    always_ff @(posedge clk) begin
        if (rst)
            pending <= 1'b0;
        else if (set)
            pending <= 1'b1;
        else if (clr)
            pending <= 1'b0;
    end

    p_set_wins_r6: assert property (@(posedge clk) disable iff (rst)
        set |=> pending);

endmodule

// File: rtl/msf_autotry.sv
module msf_autotry
    import msf_pkg::*;
#(
    parameter int SETTLE_TICKS = 400,
    parameter int DARK_TICKS   = 1,
    parameter int LIGHT_TICKS  = 20,
    parameter int POLL_TICKS   = 1000,
    parameter int POLLS_HI     = 5,
    parameter int POLLS_LO     = 1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       restart_req,
    input  logic [1:0] req_speed,
    input  logic [1:0] sup_speed,
    input  logic       link_up,
    input  logic       link_at_hi,
    input  logic       tick,
    output logic       rate_select,
    output logic       laser_off,
    output logic [1:0] adv_speed,
    output logic       done,
    output logic       fail
);
    localparam int MAXT = imax(imax(SETTLE_TICKS, DARK_TICKS), imax(LIGHT_TICKS, POLL_TICKS));
    localparam int CW   = $clog2(MAXT + 1);
    localparam int MAXP = imax(POLLS_HI, POLLS_LO);
    localparam int PW   = (MAXP > 1) ? $clog2(MAXP) : 1;
    localparam logic [PW-1:0] LAST_HI = PW'(POLLS_HI - 1);
    localparam logic [PW-1:0] LAST_LO = PW'(POLLS_LO - 1);

    msf_state_e    state;
    spd_mask_t     eff, tried;
    logic          cur_hi;
    logic [PW-1:0] polls;
    logic [CW-1:0] limit;
    logic          expire, t_clr, pending, flap_clr, last_poll;
    logic          rate_q, done_q, fail_q;
    logic [1:0]    adv_q;

    always_comb begin
        case (state)
            ST_SETTLE: limit = CW'(SETTLE_TICKS);
            ST_DARK:   limit = CW'(DARK_TICKS);
            ST_LIGHT:  limit = CW'(LIGHT_TICKS);
            ST_POLL:   limit = CW'(POLL_TICKS);
            default:   limit = CW'(1);
        endcase
    end

    assign t_clr     = !is_timed(state);
    assign flap_clr  = (state == ST_DARK) && expire;
    assign last_poll = (polls == (cur_hi ? LAST_HI : LAST_LO));

    msf_phase_timer #(.CW(CW)) u_timer (
        .clk(clk), .rst(rst), .clr(t_clr), .tick(tick), .limit(limit), .expire(expire)
    );

    msf_flap_flag u_flap (
        .clk(clk), .rst(rst), .set(restart_req), .clr(flap_clr), .pending(pending)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            eff    <= '0;
            tried  <= '0;
            cur_hi <= 1'b0;
            polls  <= '0;
            rate_q <= 1'b0;
            done_q <= 1'b0;
            fail_q <= 1'b0;
            adv_q  <= '0;
        end else begin
            done_q <= 1'b0;
            case (state)
                ST_IDLE: if (start) begin
                    eff   <= spd_mask_t'(req_speed & sup_speed);
                    tried <= '0;
                    state <= ST_CHK_HI;
                end
                ST_CHK_HI: if (eff.hi) begin
                    tried.hi <= 1'b1;
                    if (link_up && link_at_hi) begin
                        state <= ST_IDLE; done_q <= 1'b1; fail_q <= 1'b0; adv_q <= eff;
                    end else begin
                        rate_q <= 1'b1; cur_hi <= 1'b1; polls <= '0; state <= ST_SETTLE;
                    end
                end else begin
                    state <= ST_CHK_LO;
                end
                ST_CHK_LO: if (eff.lo) begin
                    tried.lo <= 1'b1;
                    if (link_up && !link_at_hi) begin
                        state <= ST_IDLE; done_q <= 1'b1; fail_q <= 1'b0; adv_q <= eff;
                    end else begin
                        rate_q <= 1'b0; cur_hi <= 1'b0; polls <= '0; state <= ST_SETTLE;
                    end
                end else begin
                    state <= ST_FALLBACK;
                end
                ST_SETTLE: if (expire) state <= pending ? ST_DARK : ST_POLL;
                ST_DARK:   if (expire) state <= ST_LIGHT;
                ST_LIGHT:  if (expire) state <= ST_POLL;
                ST_POLL: if (expire) begin
                    if (link_up) begin
                        state <= ST_IDLE; done_q <= 1'b1; fail_q <= 1'b0; adv_q <= eff;
                    end else if (last_poll) begin
                        state <= cur_hi ? ST_CHK_LO : ST_FALLBACK;
                    end else begin
                        polls <= polls + PW'(1);
                    end
                end
                ST_FALLBACK: begin
                    if (tried.hi && tried.lo) rate_q <= 1'b1;
                    state  <= ST_IDLE;
                    done_q <= 1'b1;
                    fail_q <= 1'b1;
                    adv_q  <= eff;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign rate_select = rate_q;
    assign laser_off   = (state == ST_DARK);
    assign adv_speed   = adv_q;
    assign done        = done_q;
    assign fail        = fail_q;

    // R1: moving to 10G only happens when 10G is in the effective set
    p_hi_only_if_allowed_r1: assert property (@(posedge clk) disable iff (rst)
        $rose(rate_select) |-> eff.hi);

    // R5: the laser goes dark only straight out of the settle phase
    p_dark_after_settle_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(laser_off) |-> $past(state) == ST_SETTLE);

    // R6: leaving the dark phase consumes the pending flap unless re-requested
    p_flap_consumed_r6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LIGHT && $past(state) == ST_DARK) |-> (!pending || $past(restart_req)));

    // R7: the rate select holds steady across poll windows
    p_rate_steady_poll_r7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_POLL && $past(state) == ST_POLL) |-> $stable(rate_select));

    // R9: a two-speed failure leaves the module at 10G
    p_fallback_hi_r9: assert property (@(posedge clk) disable iff (rst)
        (done && fail && tried.hi && tried.lo) |-> rate_select);

    // R10: done is a single-cycle pulse
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R11: a start during a run leaves the running speed set alone
    p_start_ignored_r11: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IDLE && start) |=> $stable(eff));

endmodule

// File: tb/sim_msf_autotry.sv
module sim_msf_autotry;
    localparam int CLK_PERIOD = 10;
    localparam int ST = 4, DK = 2, LT = 3, PT = 5, PH = 5, PL = 1;

    logic clk = 1'b0, rst = 1'b1;
    logic start = 0, restart_req = 0, link_up = 0, link_at_hi = 0, tick = 0;
    logic [1:0] req_speed = 0, sup_speed = 0;
    logic rate_select, laser_off, done, fail;
    logic [1:0] adv_speed;

    int nchk = 0, nfail = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    msf_autotry #(.SETTLE_TICKS(ST), .DARK_TICKS(DK), .LIGHT_TICKS(LT),
                  .POLL_TICKS(PT), .POLLS_HI(PH), .POLLS_LO(PL)) u0 (
        .clk(clk), .rst(rst), .start(start), .restart_req(restart_req),
        .req_speed(req_speed), .sup_speed(sup_speed), .link_up(link_up),
        .link_at_hi(link_at_hi), .tick(tick), .rate_select(rate_select),
        .laser_off(laser_off), .adv_speed(adv_speed), .done(done), .fail(fail)
    );

    // ---------------- reference model ----------------
    int ph, rem, pidx;
    bit m_cur_hi, m_rate, m_done, m_fail, m_pend, old_pend, exp_now;
    bit [1:0] m_eff, m_tried, m_adv;

    function automatic int lim_of(int p);
        case (p)
            3: return ST;
            4: return DK;
            5: return LT;
            default: return PT;
        endcase
    endfunction

    function void enter(int p);
        ph = p; rem = lim_of(p);
    endfunction

    function void fin(bit f);
        m_done = 1; m_fail = f; m_adv = m_eff; ph = 0;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            ph = 0; rem = 0; pidx = 0; m_cur_hi = 0; m_rate = 0; m_done = 0;
            m_fail = 0; m_pend = 0; m_eff = 0; m_tried = 0; m_adv = 0;
        end else begin
            old_pend = m_pend;
            m_done = 0;
            exp_now = 0;
            if (ph >= 3 && ph <= 6 && tick) begin
                rem = rem - 1;
                if (rem == 0) exp_now = 1;
            end
            case (ph)
                0: if (start) begin m_eff = req_speed & sup_speed; m_tried = 0; ph = 1; end
                1: if (m_eff[1]) begin
                       m_tried[1] = 1;
                       if (link_up && link_at_hi) fin(0);
                       else begin m_rate = 1; m_cur_hi = 1; pidx = 0; enter(3); end
                   end else ph = 2;
                2: if (m_eff[0]) begin
                       m_tried[0] = 1;
                       if (link_up && !link_at_hi) fin(0);
                       else begin m_rate = 0; m_cur_hi = 0; pidx = 0; enter(3); end
                   end else ph = 7;
                3: if (exp_now) enter(old_pend ? 4 : 6);
                4: if (exp_now) begin m_pend = 0; enter(5); end
                5: if (exp_now) enter(6);
                6: if (exp_now) begin
                       if (link_up) fin(0);
                       else if (pidx == (m_cur_hi ? PH : PL) - 1) ph = m_cur_hi ? 2 : 7;
                       else begin pidx = pidx + 1; enter(6); end
                   end
                default: begin if (m_tried == 2'b11) m_rate = 1; fin(1); end
            endcase
            if (restart_req) m_pend = 1;
        end
    end

    // ---------------- checking ----------------
    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    initial forever begin
        @(negedge clk);
        if (!rst && !finished) begin
            chk(rate_select == m_rate, "R2 rate_select vs model", rate_select, m_rate);
            chk(laser_off == (ph == 4), "R5 laser_off vs model", laser_off, ph == 4);
            chk(adv_speed == m_adv, "R10 adv_speed vs model", adv_speed, m_adv);
            chk(done == m_done, "R10 done vs model", done, m_done);
            chk(fail == m_fail, "R10 fail vs model", fail, m_fail);
        end
    end

    // timebase: one tick every second cycle
    initial forever begin
        @(negedge clk);
        tick = ~tick;
    end

    // run results
    int r_cyc, r_laser_cyc, r_laser_pulses, r_dones;
    bit r_rate_hi_seen, r_rate_changed;

    task automatic run(input bit [1:0] rq, input bit [1:0] sp, input bit lhi,
                       input int link_at, input int restart_at);
        bit prev_laser, r0;
        req_speed = rq; sup_speed = sp; link_at_hi = lhi;
        link_up = (link_at == 0);
        r_cyc = 0; r_laser_cyc = 0; r_laser_pulses = 0; r_dones = 0;
        r_rate_hi_seen = 0; r_rate_changed = 0; prev_laser = 0;
        @(negedge clk);
        r0 = rate_select;
        start = 1;
        @(negedge clk);
        start = 0;
        while (r_cyc < 2000) begin
            @(negedge clk);
            r_cyc++;
            if (r_cyc == link_at) link_up = 1;
            start = (r_cyc == restart_at);
            if (laser_off) r_laser_cyc++;
            if (laser_off && !prev_laser) r_laser_pulses++;
            prev_laser = laser_off;
            if (rate_select) r_rate_hi_seen = 1;
            if (rate_select != r0) r_rate_changed = 1;
            if (done) begin r_dones++; break; end
        end
        start = 0;
        repeat (20) begin
            @(negedge clk);
            if (done) r_dones++;
        end
        link_up = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R13: reset values
        chk(rate_select == 0, "R13 rate_select after reset", rate_select, 0);
        chk(laser_off == 0, "R13 laser_off after reset", laser_off, 0);
        chk(adv_speed == 0, "R13 adv_speed after reset", adv_speed, 0);
        chk(done == 0 && fail == 0, "R13 done/fail after reset", {done, fail}, 0);

        // R1/R8: both requested, only 1G supported, link arrives during the 1G window
        run(2'b11, 2'b01, 0, 6, -1);
        chk(!r_rate_hi_seen, "R1 unsupported 10G never selected", r_rate_hi_seen, 0);
        chk(fail == 0, "R8 1G attempt links", fail, 0);
        chk(adv_speed == 2'b01, "R10 adv equals effective set", adv_speed, 1);

        // R9: one speed tried, no link -> no fallback to 10G
        run(2'b11, 2'b01, 0, -1, -1);
        chk(fail == 1, "R9 single-speed failure flagged", fail, 1);
        chk(rate_select == 0, "R9 single-speed failure stays at 1G", rate_select, 0);
        chk(r_laser_pulses == 0, "R5 no flap without request", r_laser_pulses, 0);

        // R5/R6/R9: flap requested, both speeds, never links
        @(negedge clk); restart_req = 1; @(negedge clk); restart_req = 0;
        run(2'b11, 2'b11, 1, -1, -1);
        chk(r_laser_pulses == 1, "R6 one flap per request", r_laser_pulses, 1);
        chk(r_laser_cyc == 2 * DK, "R5 dark length in cycles", r_laser_cyc, 2 * DK);
        chk(fail == 1, "R9 two-speed failure flagged", fail, 1);
        chk(rate_select == 1, "R9 fallback to 10G", rate_select, 1);
        chk(adv_speed == 2'b11, "R10 adv both speeds", adv_speed, 3);

        // R3: already linked at 10G
        run(2'b10, 2'b11, 1, 0, -1);
        chk(r_cyc == 1, "R3 immediate exit cycle count", r_cyc, 1);
        chk(!r_rate_changed && fail == 0, "R3 no rate change, success", fail, 0);

        // R7/R11: 10G links during third window, stray start mid-run
        run(2'b10, 2'b10, 1, 35, 12);
        chk(fail == 0, "R7 10G links within poll windows", fail, 0);
        chk(r_dones == 1, "R11 stray start gives one done", r_dones, 1);
        chk(adv_speed == 2'b10, "R11 speed set kept", adv_speed, 2);
        chk(r_cyc > 2 * (ST + 2 * PT), "R7 link seen only after later window", r_cyc, 2 * (ST + 2 * PT));

        // R12: empty effective set
        run(2'b01, 2'b10, 0, -1, -1);
        chk(r_cyc == 3, "R12 empty set exit cycle", r_cyc, 3);
        chk(fail == 1 && adv_speed == 0, "R12 empty set fails, adv 0", {fail, adv_speed}, 4);
        chk(!r_rate_changed, "R12 rate untouched", r_rate_changed, 0);

        // R4: settle length before polling with no flap (link present from the first poll)
        run(2'b01, 2'b01, 1, 1, -1);
        chk(r_cyc >= 2 * ST + 2 * PT - 1, "R4 settle then poll before done", r_cyc, 2 * ST + 2 * PT);

        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            nchk++; nfail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

endmodule